// File: doc/BRIEF.md
# Serial Receive Address Filter

This block sits after the bit-level receiver of a classic 8-bit microcontroller UART. It decides whether a completed frame raises the receive-interrupt flag, and it records framing errors. A programmable station address and an enable mask select which received bytes interrupt the processor. Bytes that do not match are dropped without disturbing software.

In the multiprocessor modes, a ninth-bit qualifier can limit the comparison to address frames. A power-control option bit decides how bit 7 of the control register behaves. In one setting it holds the high serial-mode bit. In the other it is the sticky framing-error flag, which only software can clear.

Software programs the block through a narrow write bus. The bus carries a 2-bit register select and a data word. The current value of control bit 7 is always visible on a readback port.

Top module: `uart_rx_addr_gate`

## Requirements
- R1: A frame matches when, for every bit set in the mask register (select 1 holds the address, select 2 holds the mask), the received byte equals the address register. A zero mask accepts every byte. In modes 1 to 3, a matching frame sets the receive flag on the clock edge that samples frame_done.
- R2: A frame that is not accepted leaves the receive flag unchanged. Once set, the receive flag stays set until software writes bit 0 of the control register (select 0) as 0.
- R3: In mode 0 (control bits 7:6 = 00, with bit 7 acting as the mode bit), every completed frame sets the receive flag whatever the mask, address or stop bit, and the error flag is never set.
- R4: Control bit 5 enables multiprocessor filtering. In modes 2 and 3, with this bit set, a frame whose ninth bit is 0 is accepted without comparison and a frame whose ninth bit is 1 is compared. With the bit clear, every frame is compared. In mode 1 the bit has no effect.
- R5: In modes 1 to 3, a completed frame with an invalid stop bit sets the error flag, even when the address filter discards the frame.
- R6: Hardware never clears the error flag. A control write with option bit 6 set writes bit 7 into the error flag. When such a write and a new error occur in the same cycle, the flag ends up set.
- R7: Option register (select 3) bit 6 routes control bit 7. When it is 1, bit 7 writes and reads the error flag. When it is 0, bit 7 writes and reads the high mode bit. The field that is not selected is not altered by the write.
- R8: After reset, the receive flag, the error flag, the mode bits, the option bit and the readback are all 0.
- R9: When a software write to the receive flag and an accepted frame fall in the same cycle, the receive flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe marking a completed frame |
| rx_byte | input | DATA_W | Received data byte |
| rx_bit9 | input | 1 | Received ninth bit |
| stop_ok | input | 1 | Stop bit was valid for this frame |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 address, 2 mask, 3 option |
| wr_data | input | DATA_W | Register write data |
| ri_flag | output | 1 | Sticky receive-interrupt flag |
| fe_flag | output | 1 | Sticky framing-error flag |
| ctl7_rd | output | 1 | Readback of control bit 7 (error flag or high mode bit) |

## Verification
A wrong match mask or a corrupted address register shows up on ri_flag one edge after the offending frame_done: a byte that should be accepted is dropped, or the reverse. Because ri_flag is sticky, the bench clears it before every frame so each vector is judged alone. A mode bit stored in the wrong place, or a write routed wrongly, is visible on ctl7_rd on the edge after the write or the option change. It also changes whether mode 0 bypasses the filter on the next frame. An error flag cleared by hardware becomes visible at fe_flag after the first clean frame that follows a bad one.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_CTL  = 2'd0,
      SEL_SADR = 2'd1,
      SEL_MASK = 2'd2,
      SEL_OPT  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      MODE_SHIFT = 2'd0,
      MODE_8BIT  = 2'd1,
      MODE_9FIX  = 2'd2,
      MODE_9VAR  = 2'd3
   } ser_mode_e;
endpackage

// File: rtl/rxg_cfg_regs.sv
module rxg_cfg_regs #(
   parameter int unsigned DATA_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [rxg_pkg::SEL_W-1:0]      wr_sel,
   input  logic [DATA_W-1:0]              wr_data,
   output logic                           sm0_q,
   output logic                           sm1_q,
   output logic                           mp_en_q,
   output logic                           fe_sel_q,
   output logic [DATA_W-1:0]              saddr_q,
   output logic [DATA_W-1:0]              smask_q
);
   localparam int unsigned B_TOP = DATA_W - 1;
   localparam int unsigned B_SM1 = DATA_W - 2;
   localparam int unsigned B_MP  = DATA_W - 3;
   localparam int unsigned B_OPT = DATA_W - 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sm0_q    <= 1'b0;
         sm1_q    <= 1'b0;
         mp_en_q  <= 1'b0;
         fe_sel_q <= 1'b0;
         saddr_q  <= '0;
         smask_q  <= '0;
      end else if (wr_en) begin
         case (rxg_pkg::reg_sel_e'(wr_sel))
            rxg_pkg::SEL_CTL: begin
               if (!fe_sel_q) sm0_q <= wr_data[B_TOP];
               sm1_q   <= wr_data[B_SM1];
               mp_en_q <= wr_data[B_MP];
            end
            rxg_pkg::SEL_SADR: saddr_q  <= wr_data;
            rxg_pkg::SEL_MASK: smask_q  <= wr_data;
            rxg_pkg::SEL_OPT:  fe_sel_q <= wr_data[B_OPT];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rxg_addr_match.sv
module rxg_addr_match #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] saddr,
   input  logic [DATA_W-1:0] smask,
   output logic              hit
);
   logic [DATA_W-1:0] bit_ok;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign bit_ok[g] = !smask[g] || (rx_byte[g] == saddr[g]);
   end

   assign hit = &bit_ok;
endmodule

// File: rtl/rxg_sticky_bit.sv
module rxg_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (hw_set) q <= 1'b1;
      else if (sw_wr)  q <= sw_val;
   end
endmodule

// File: rtl/uart_rx_addr_gate.sv
module uart_rx_addr_gate #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MP_FILTER = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_done,
   input  logic [DATA_W-1:0]         rx_byte,
   input  logic                      rx_bit9,
   input  logic                      stop_ok,
   input  logic                      wr_en,
   input  logic [1:0]                wr_sel,
   input  logic [DATA_W-1:0]         wr_data,
   output logic                      ri_flag,
   output logic                      fe_flag,
   output logic                      ctl7_rd
);
   localparam int unsigned B_TOP = DATA_W - 1;

   if (DATA_W < 4) begin : g_chk_w
      $error("uart_rx_addr_gate: DATA_W must be at least 4");
   end
   if (MP_FILTER > 1) begin : g_chk_mp
      $error("uart_rx_addr_gate: MP_FILTER must be 0 or 1");
   end

   logic              sm0_q, sm1_q, mp_en_q, fe_sel_q;
   logic [DATA_W-1:0] saddr_q, smask_q;
   logic              addr_hit, data_pass, is_shift, accept, ctl_wr;

   rxg_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .sm0_q    (sm0_q),
      .sm1_q    (sm1_q),
      .mp_en_q  (mp_en_q),
      .fe_sel_q (fe_sel_q),
      .saddr_q  (saddr_q),
      .smask_q  (smask_q)
   );

   rxg_addr_match #(.DATA_W(DATA_W)) u_match (
      .rx_byte (rx_byte),
      .saddr   (saddr_q),
      .smask   (smask_q),
      .hit     (addr_hit)
   );

   if (MP_FILTER == 1) begin : g_mp
      assign data_pass = mp_en_q && sm0_q && !rx_bit9;
   end else begin : g_no_mp
      assign data_pass = 1'b0;
   end

   assign is_shift = (rxg_pkg::ser_mode_e'({sm0_q, sm1_q}) == rxg_pkg::MODE_SHIFT);
   assign accept   = is_shift || data_pass || addr_hit;
   assign ctl_wr   = wr_en && (rxg_pkg::reg_sel_e'(wr_sel) == rxg_pkg::SEL_CTL);

   rxg_sticky_bit u_ri (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (frame_done && accept),
      .sw_wr  (ctl_wr),
      .sw_val (wr_data[0]),
      .q      (ri_flag)
   );

   rxg_sticky_bit u_fe (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (frame_done && !is_shift && !stop_ok),
      .sw_wr  (ctl_wr && fe_sel_q),
      .sw_val (wr_data[B_TOP]),
      .q      (fe_flag)
   );

   assign ctl7_rd = fe_sel_q ? fe_flag : sm0_q;
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_done,
   input logic              stop_ok,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              ri_flag,
   input logic              fe_flag,
   input logic              ctl7_rd,
   input logic              sm0,
   input logic              sm1,
   input logic              fe_sel,
   input logic [DATA_W-1:0] smask
);
   logic ctl_w, opt_w;
   assign ctl_w = wr_en && (wr_sel == 2'd0);
   assign opt_w = wr_en && (wr_sel == 2'd3);

   assert_mask0_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !sm0 && sm1 && (smask == '0)) |=> ri_flag);

   assert_ri_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !ctl_w) |=> $stable(ri_flag));

   assert_shift_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !sm0 && !sm1) |=> ri_flag);

   assert_fe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !stop_ok && (sm0 || sm1)) |=> fe_flag);

   assert_fe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_flag && !(ctl_w && fe_sel && !wr_data[DATA_W-1])) |=> fe_flag);

   assert_ctl7_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fe_sel && !ctl_w && !opt_w) |=> $stable(ctl7_rd));

   assert_rst_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (!ri_flag && !fe_flag && !ctl7_rd));
endmodule

bind uart_rx_addr_gate rxg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_done (frame_done),
   .stop_ok    (stop_ok),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .ri_flag    (ri_flag),
   .fe_flag    (fe_flag),
   .ctl7_rd    (ctl7_rd),
   .sm0        (sm0_q),
   .sm1        (sm1_q),
   .fe_sel     (fe_sel_q),
   .smask      (smask_q)
);

// File: tb/tb_uart_rx_addr_gate.sv
module tb_uart_rx_addr_gate;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_done = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_bit9 = 1'b0;
   logic       stop_ok = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       ri_flag, fe_flag, ctl7_rd;
   int         total = 0;
   int         bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_addr_gate dut (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_byte(rx_byte),
      .rx_bit9(rx_bit9), .stop_ok(stop_ok), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ri_flag(ri_flag), .fe_flag(fe_flag), .ctl7_rd(ctl7_rd)
   );

   typedef struct packed {
      logic [1:0] mode;
      logic       mp;
      logic [7:0] sa;
      logic [7:0] mk;
      logic [7:0] by;
      logic       b9;
      logic       st;
      logic       eri;
      logic       efe;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 1'b0, 8'h5A, 8'hFF, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd1, 1'b0, 8'h5A, 8'hFF, 8'h5B, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd1, 1'b0, 8'h5A, 8'h00, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd1, 1'b0, 8'hA5, 8'hF0, 8'hAC, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd1, 1'b0, 8'hA5, 8'hF0, 8'hB5, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd0, 1'b0, 8'h00, 8'hFF, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd1, 1'b0, 8'h12, 8'hFF, 8'h13, 1'b0, 1'b0, 1'b0, 1'b1},
      '{2'd1, 1'b0, 8'h12, 8'hFF, 8'h12, 1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd2, 1'b1, 8'h3C, 8'hFF, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd2, 1'b1, 8'h3C, 8'hFF, 8'h3D, 1'b1, 1'b1, 1'b0, 1'b0},
      '{2'd3, 1'b1, 8'h3C, 8'hFF, 8'h99, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd3, 1'b0, 8'h3C, 8'hFF, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd2, 1'b0, 8'h3C, 8'hFF, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic frame(input logic [7:0] b, input logic b9, input logic st);
      @(negedge clk);
      frame_done = 1'b1; rx_byte = b; rx_bit9 = b9; stop_ok = st;
      @(negedge clk);
      frame_done = 1'b0; stop_ok = 1'b1;
   endtask

   task automatic setup(input logic [1:0] mode, input logic mp,
                        input logic [7:0] sa, input logic [7:0] mk);
      wr(2'd3, 8'h40);
      wr(2'd0, {1'b0, mode[0], mp, 5'b0});
      wr(2'd3, 8'h00);
      wr(2'd0, {mode[1], mode[0], mp, 5'b0});
      wr(2'd1, sa);
      wr(2'd2, mk);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 ri reset", ri_flag, 1'b0);
      check("R8 fe reset", fe_flag, 1'b0);
      check("R8 ctl7 reset", ctl7_rd, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         setup(VECS[i].mode, VECS[i].mp, VECS[i].sa, VECS[i].mk);
         frame(VECS[i].by, VECS[i].b9, VECS[i].st);
         check($sformatf("R1 R3 R4 vec%0d ri", i), ri_flag, VECS[i].eri);
         check($sformatf("R5 vec%0d fe", i), fe_flag, VECS[i].efe);
         check($sformatf("R7 vec%0d ctl7 mode bit", i), ctl7_rd, VECS[i].mode[1]);
      end

      // R2: sticky receive flag, cleared only by software
      setup(2'd1, 1'b0, 8'h11, 8'hFF);
      frame(8'h11, 1'b0, 1'b1);
      check("R2 ri set", ri_flag, 1'b1);
      frame(8'h22, 1'b0, 1'b1);
      check("R2 ri kept after reject", ri_flag, 1'b1);
      wr(2'd0, 8'h40);
      check("R2 ri sw clear", ri_flag, 1'b0);

      // R6: error flag sticky and priority
      frame(8'h55, 1'b0, 1'b0);
      check("R6 fe set", fe_flag, 1'b1);
      wr(2'd2, 8'h00);
      frame(8'h55, 1'b0, 1'b1);
      check("R6 fe kept after clean frame", fe_flag, 1'b1);
      wr(2'd0, 8'h40);
      check("R6 fe not cleared with option 0", fe_flag, 1'b1);
      wr(2'd3, 8'h40);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h40;
      frame_done = 1'b1; rx_byte = 8'h01; stop_ok = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; frame_done = 1'b0; stop_ok = 1'b1;
      check("R6 hw set wins over clear", fe_flag, 1'b1);
      check("R9 ri set wins over clear", ri_flag, 1'b1);
      wr(2'd0, 8'h40);
      check("R6 fe sw clear", fe_flag, 1'b0);
      check("R2 ri cleared with fe", ri_flag, 1'b0);

      // R7: dual-function bit 7
      wr(2'd3, 8'h00);
      wr(2'd0, 8'hC0);
      check("R7 ctl7 shows mode bit", ctl7_rd, 1'b1);
      wr(2'd3, 8'h40);
      check("R7 ctl7 shows fe", ctl7_rd, 1'b0);
      wr(2'd0, 8'hC0);
      check("R7 fe written by sw", fe_flag, 1'b1);
      wr(2'd3, 8'h00);
      check("R7 mode bit kept", ctl7_rd, 1'b1);
      wr(2'd0, 8'h40);
      check("R7 mode bit cleared", ctl7_rd, 1'b0);
      wr(2'd3, 8'h40);
      check("R7 fe untouched by mode write", ctl7_rd, 1'b1);

      // R3: mode 0 has no error flag even with bad stop
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h00);
      frame(8'hFE, 1'b0, 1'b0);
      check("R3 mode0 ri", ri_flag, 1'b1);
      wr(2'd3, 8'h40);
      check("R3 mode0 fe stays 0", fe_flag, 1'b0);

      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 ri after reset", ri_flag, 1'b0);
      check("R8 ctl7 after reset", ctl7_rd, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule